// File: doc/BRIEF.md
# Parallel Display Bus Master (8080-style strobes)

This block connects a host-side request port to a display controller over an 8080-style parallel bus. It drives an active-low chip select, a data/command level, separate active-low read and write strobes, and a data bus whose width is set at build time to 8 or 16 bits. The bus has one output direction and one input direction, and an output enable controls the turnaround.

The host issues one request at a time. A request is a command-index write, an 8- or 16-bit data write, a status read, or an 8- or 16-bit data read. The block sequences the chip-select window and the strobe beats. It splits or merges 16-bit values to fit the bus width. Every data read starts with a dummy beat. At the end of each request the block pulses `done_o`, and a read result is presented on `rd_data_o`.

The strobe half-period is set by an even divider sampled when a request is accepted. After each transaction the chip select stays high for one half-period before the block accepts the next request.

Top module: `disp_bus_master`

## Requirements
- R1: After reset, `bus_cs_n`, `bus_rd_n` and `bus_wr_n` are high, `bus_oe` is low, and `busy_o` and `done_o` are low.
- R2: `req_op` codes are: 0 command write, 1 data write 8-bit, 2 data write 16-bit, 3 status read, 4 data read 8-bit, 5 data read 16-bit. A request is taken on a clock edge where `req_valid` is high and `busy_o` is low. Codes 6 and 7, and any request made while `busy_o` is high, start no bus activity.
- R3: A command write makes one write beat with `bus_dc` low for the whole chip-select window. The beat carries `req_wdata[7:0]` on the low bus byte, with a zero upper byte on a 16-bit bus. `bus_dc` returns high in the same cycle that `bus_cs_n` rises.
- R4: A status read makes one read beat with `bus_dc` low, and `bus_wr_n` stays high throughout.
- R5: Data reads and data writes hold `bus_dc` high while `bus_cs_n` is low. A data read makes exactly two read beats inside one chip-select window, and the first beat is a dummy.
- R6: An 8-bit data write puts `req_wdata[7:0]` on the bus. On an 8-bit bus, a 16-bit data write sends `req_wdata[15:8]` and then `req_wdata[7:0]` in one chip-select window. On a 16-bit bus it sends the whole word in a single beat.
- R7: On an 8-bit bus, a 16-bit read returns {first byte, second byte}. An 8-bit data read returns {8'h00, second byte}. A status read returns {8'h00, the byte}.
- R8: On a 16-bit bus, a 16-bit read returns the second captured word with its bytes swapped. An 8-bit data read returns {8'h00, upper byte of the second word}. A status read returns {8'h00, upper byte of its word}.
- R9: With H = `div_i`/2 rounded down, and 1 when that is 0, each strobe is low for H cycles and high for H cycles. Chip select falls H cycles before the first strobe. The divider is sampled only when a request is accepted.
- R10: Read data is captured on the clock edge where the read strobe rises, so the value present during the last low cycle is the one returned.
- R11: `bus_oe` is high for the whole chip-select window of a write and is low otherwise. The read and write strobes are never low together.
- R12: `done_o` is a one-cycle pulse in the first cycle that `bus_cs_n` is high again. `busy_o` stays high for H cycles starting with that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Request code |
| req_wdata | input | 16 | Write value or command index |
| div_i | input | DIV_W | Strobe divider (even, at least 2) |
| busy_o | output | 1 | Transaction or recovery gap in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | 16 | Last read result |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_dc | output | 1 | Data (high) or command/status (low) |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_oe | output | 1 | Data bus output enable |
| bus_dout | output | BUS_W | Data bus output value |
| bus_din | input | BUS_W | Data bus input value |

## Verification
The bench runs both bus widths. It targets byte order: a design that swaps the beat order of a split write, or merges the dummy byte on the wrong side, returns 0xFF01 where 0x01FF is expected. The bus model changes its data just after each read strobe rises, so a design that samples late or on the falling edge returns a wrong value. It also checks odd and zero divider values, a request made while busy, and unused codes. A design that re-samples the divider, queues the extra request, or starts on an unused code shows up as a wrong strobe width or an unexpected beat.

// File: rtl/dbm_pkg.sv
`timescale 1ns/1ps
package dbm_pkg;

    typedef enum logic [2:0] {
        OP_CMD_WR   = 3'd0,
        OP_DAT_WR8  = 3'd1,
        OP_DAT_WR16 = 3'd2,
        OP_STAT_RD  = 3'd3,
        OP_DAT_RD8  = 3'd4,
        OP_DAT_RD16 = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_GAP
    } st_e;

    function automatic logic op_known(input logic [2:0] code);
        return code <= 3'd5;
    endfunction

    function automatic logic op_reads(input op_e op);
        return (op == OP_STAT_RD) || (op == OP_DAT_RD8) || (op == OP_DAT_RD16);
    endfunction

    // command index and status access run with the level low
    function automatic logic op_dc_level(input op_e op);
        return !((op == OP_CMD_WR) || (op == OP_STAT_RD));
    endfunction

endpackage

// File: rtl/dbm_half_timer.sv
`timescale 1ns/1ps
module dbm_half_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire = (cnt_q == '0);

    AST_TMR_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(load_val))); // R9

endmodule

// File: rtl/dbm_op_plan.sv
`timescale 1ns/1ps
module dbm_op_plan
    import dbm_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  op_e              op,
    input  logic [15:0]      wdata,
    input  logic             beat,
    output logic             two_beats,
    output logic [BUS_W-1:0] wbeat
);

    logic is_data_rd;
    assign is_data_rd = (op == OP_DAT_RD8) || (op == OP_DAT_RD16);

    generate
        if (BUS_W == 8) begin : g_narrow
            // a wide write is split, high byte on the first beat
            assign two_beats = is_data_rd || (op == OP_DAT_WR16);
            assign wbeat     = ((op == OP_DAT_WR16) && !beat) ? wdata[15:8] : wdata[7:0];
        end else begin : g_wide
            logic unused_beat;
            assign unused_beat = beat;
            assign two_beats   = is_data_rd;
            assign wbeat       = (op == OP_DAT_WR16) ? wdata : {8'h00, wdata[7:0]};
        end
    endgenerate

endmodule

// File: rtl/dbm_rd_merge.sv
`timescale 1ns/1ps
module dbm_rd_merge
    import dbm_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  op_e              op,
    input  logic [BUS_W-1:0] cap0,
    input  logic [BUS_W-1:0] cap1,
    output logic [15:0]      result
);

    generate
        if (BUS_W == 8) begin : g_narrow
            always_comb begin
                unique case (op)
                    OP_STAT_RD:  result = {8'h00, cap0};
                    OP_DAT_RD16: result = {cap0, cap1};
                    default:     result = {8'h00, cap1};
                endcase
            end
        end else begin : g_wide
            logic unused_low;
            assign unused_low = ^cap0[7:0];
            always_comb begin
                unique case (op)
                    OP_STAT_RD:  result = {8'h00, cap0[15:8]};
                    OP_DAT_RD16: result = {cap1[7:0], cap1[15:8]};
                    default:     result = {8'h00, cap1[15:8]};
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/disp_bus_master.sv
`timescale 1ns/1ps
module disp_bus_master
    import dbm_pkg::*;
#(
    parameter int BUS_W = 16,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_op,
    input  logic [15:0]      req_wdata,
    input  logic [DIV_W-1:0] div_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [15:0]      rd_data_o,
    output logic             bus_cs_n,
    output logic             bus_dc,
    output logic             bus_rd_n,
    output logic             bus_wr_n,
    output logic             bus_oe,
    output logic [BUS_W-1:0] bus_dout,
    input  logic [BUS_W-1:0] bus_din
);

    localparam int HW = DIV_W - 1;

    typedef struct packed {
        st_e              st;
        op_e              op;
        logic [HW-1:0]    half;
        logic [1:0]       edges;
        logic             beat;
        logic             cs_n;
        logic             dc;
        logic             rd_n;
        logic             wr_n;
        logic             oe;
        logic             done;
        logic [BUS_W-1:0] dout;
        logic [BUS_W-1:0] cap0;
        logic [BUS_W-1:0] cap1;
        logic [15:0]      wdata;
        logic [15:0]      rdat;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             tmr_load;
    logic [HW-1:0]    tmr_val;
    logic             tmr_exp;
    op_e              plan_op;
    logic [15:0]      plan_wd;
    logic             plan_beat;
    logic             plan_two;
    logic [BUS_W-1:0] plan_wbeat;
    logic [15:0]      merged;
    logic [HW-1:0]    half_new;
    logic             unused_div;

    // divider below 2 behaves as 2, odd values round down
    assign half_new   = (div_i[DIV_W-1:1] == '0) ? HW'(1) : div_i[DIV_W-1:1];
    assign unused_div = div_i[0];

    assign plan_op   = (ctl_q.st == ST_IDLE) ? op_e'(req_op) : ctl_q.op;
    assign plan_wd   = (ctl_q.st == ST_IDLE) ? req_wdata : ctl_q.wdata;
    assign plan_beat = (ctl_q.st != ST_IDLE);

    dbm_op_plan #(.BUS_W(BUS_W)) i_plan (
        .op        (plan_op),
        .wdata     (plan_wd),
        .beat      (plan_beat),
        .two_beats (plan_two),
        .wbeat     (plan_wbeat)
    );

    dbm_rd_merge #(.BUS_W(BUS_W)) i_merge (
        .op     (ctl_q.op),
        .cap0   (ctl_q.cap0),
        .cap1   (ctl_q.cap1),
        .result (merged)
    );

    dbm_half_timer #(.CNT_W(HW)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_exp)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = ctl_q.half - 1'b1;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid && op_known(req_op)) begin
                    ctl_d.st    = ST_SETUP;
                    ctl_d.op    = op_e'(req_op);
                    ctl_d.half  = half_new;
                    ctl_d.wdata = req_wdata;
                    ctl_d.cs_n  = 1'b0;
                    ctl_d.dc    = op_dc_level(op_e'(req_op));
                    ctl_d.oe    = !op_reads(op_e'(req_op));
                    ctl_d.dout  = plan_wbeat;
                    tmr_load    = 1'b1;
                    tmr_val     = half_new - 1'b1;
                end
            end
            ST_SETUP: begin
                if (tmr_exp) begin
                    ctl_d.st    = ST_STROBE;
                    ctl_d.edges = plan_two ? 2'd3 : 2'd1;
                    ctl_d.beat  = 1'b0;
                    if (op_reads(ctl_q.op)) begin
                        ctl_d.rd_n = 1'b0;
                    end else begin
                        ctl_d.wr_n = 1'b0;
                    end
                    tmr_load = 1'b1;
                end
            end
            ST_STROBE: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    if (ctl_q.edges[0]) begin
                        // strobe rises here: capture the bus on this edge
                        if (op_reads(ctl_q.op)) begin
                            if (!ctl_q.beat) begin
                                ctl_d.cap0 = bus_din;
                            end else begin
                                ctl_d.cap1 = bus_din;
                            end
                        end
                        ctl_d.rd_n  = 1'b1;
                        ctl_d.wr_n  = 1'b1;
                        ctl_d.edges = ctl_q.edges - 1'b1;
                    end else if (ctl_q.edges == 2'd0) begin
                        ctl_d.st   = ST_GAP;
                        ctl_d.cs_n = 1'b1;
                        ctl_d.dc   = 1'b1;
                        ctl_d.oe   = 1'b0;
                        ctl_d.done = 1'b1;
                        if (op_reads(ctl_q.op)) begin
                            ctl_d.rdat = merged;
                        end
                    end else begin
                        ctl_d.edges = ctl_q.edges - 1'b1;
                        ctl_d.beat  = 1'b1;
                        ctl_d.dout  = plan_wbeat;
                        if (op_reads(ctl_q.op)) begin
                            ctl_d.rd_n = 1'b0;
                        end else begin
                            ctl_d.wr_n = 1'b0;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (tmr_exp) begin
                    ctl_d.st = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.st    <= ST_IDLE;
            ctl_q.op    <= OP_CMD_WR;
            ctl_q.half  <= HW'(1);
            ctl_q.cs_n  <= 1'b1;
            ctl_q.dc    <= 1'b1;
            ctl_q.rd_n  <= 1'b1;
            ctl_q.wr_n  <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o    = (ctl_q.st != ST_IDLE);
    assign done_o    = ctl_q.done;
    assign rd_data_o = ctl_q.rdat;
    assign bus_cs_n  = ctl_q.cs_n;
    assign bus_dc    = ctl_q.dc;
    assign bus_rd_n  = ctl_q.rd_n;
    assign bus_wr_n  = ctl_q.wr_n;
    assign bus_oe    = ctl_q.oe;
    assign bus_dout  = ctl_q.dout;

    // length of the current strobe-low run, for the width check
    logic [HW-1:0] low_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run_q <= '0;
        end else if (!bus_rd_n || !bus_wr_n) begin
            low_run_q <= low_run_q + 1'b1;
        end else begin
            low_run_q <= '0;
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n)); // R11
    AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !bus_wr_n) |-> !bus_cs_n); // R5
    AST_OE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (bus_rd_n && !bus_cs_n)); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R12
    AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cs_n) |-> done_o); // R12
    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rd_n && bus_wr_n) |-> (low_run_q == ctl_q.half)); // R9
    AST_STATUS_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && !bus_dc && !bus_rd_n) |-> bus_wr_n); // R4
    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_valid && op_known(req_op)) |=> !bus_cs_n); // R2
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && bus_cs_n && !done_o) |=> bus_cs_n); // R2

endmodule

// File: tb/test_disp_bus_master.sv
`timescale 1ns/1ps
module test_disp_bus_master;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        v16 = 1'b0, v8 = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [15:0] wd = 16'h0;
    logic [7:0]  dv = 8'd2;

    logic        b16_busy, b16_done, b16_cs_n, b16_dc, b16_rd_n, b16_wr_n, b16_oe;
    logic [15:0] b16_rdat, b16_dout;
    logic [15:0] din16 = 16'h0;
    logic        b8_busy, b8_done, b8_cs_n, b8_dc, b8_rd_n, b8_wr_n, b8_oe;
    logic [15:0] b8_rdat;
    logic [7:0]  b8_dout;
    logic [7:0]  din8 = 8'h0;

    disp_bus_master #(.BUS_W(16), .DIV_W(8)) i_disp_bus_master (
        .clk(clk), .rst_n(rst_n), .req_valid(v16), .req_op(op), .req_wdata(wd), .div_i(dv),
        .busy_o(b16_busy), .done_o(b16_done), .rd_data_o(b16_rdat),
        .bus_cs_n(b16_cs_n), .bus_dc(b16_dc), .bus_rd_n(b16_rd_n), .bus_wr_n(b16_wr_n),
        .bus_oe(b16_oe), .bus_dout(b16_dout), .bus_din(din16));

    disp_bus_master #(.BUS_W(8), .DIV_W(8)) i_disp_bus_master_b8 (
        .clk(clk), .rst_n(rst_n), .req_valid(v8), .req_op(op), .req_wdata(wd), .div_i(dv),
        .busy_o(b8_busy), .done_o(b8_done), .rd_data_o(b8_rdat),
        .bus_cs_n(b8_cs_n), .bus_dc(b8_dc), .bus_rd_n(b8_rd_n), .bus_wr_n(b8_wr_n),
        .bus_oe(b8_oe), .bus_dout(b8_dout), .bus_din(din8));

    int sel = 0; // 0: 16-bit bus, 1: 8-bit bus
    logic        m_busy, m_done, m_cs_n, m_dc, m_rd_n, m_wr_n, m_oe;
    logic [15:0] m_rdat, m_dout;
    always_comb begin
        if (sel == 1) begin
            m_busy = b8_busy; m_done = b8_done; m_cs_n = b8_cs_n; m_dc = b8_dc;
            m_rd_n = b8_rd_n; m_wr_n = b8_wr_n; m_oe = b8_oe; m_rdat = b8_rdat;
            m_dout = {8'h00, b8_dout};
        end else begin
            m_busy = b16_busy; m_done = b16_done; m_cs_n = b16_cs_n; m_dc = b16_dc;
            m_rd_n = b16_rd_n; m_wr_n = b16_wr_n; m_oe = b16_oe; m_rdat = b16_rdat;
            m_dout = b16_dout;
        end
    end

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // scoreboard queues: beat items {is_read, dc, data} and result items {check, value}
    logic [17:0] beat_q[$];
    string       beat_tag_q[$];
    logic [16:0] res_q[$];
    string       res_tag_q[$];

    int          cur_h = 1;
    logic        cur_dc = 1'b1;
    logic        cur_wr = 1'b0;
    string       cur_tag = "R5";
    logic [15:0] rd_vals [2];

    // bus model and monitor
    int          low_cnt = 0, setup_cnt = 0, rd_idx = 0;
    bit          seen_strobe = 0, rd_drv = 0;
    logic        prev_wr = 1'b1, prev_rd = 1'b1, last_dc = 1'b1;
    logic [15:0] wr_dat = 16'h0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!m_cs_n) begin
                chk(m_dc == cur_dc, cur_tag, "dc level in window", {15'h0, m_dc}, {15'h0, cur_dc});
                chk(m_oe == cur_wr, "R11", "oe in window", {15'h0, m_oe}, {15'h0, cur_wr});
                if (m_rd_n && m_wr_n && !seen_strobe) setup_cnt++;
            end else begin
                seen_strobe = 0;
                setup_cnt   = 0;
            end
            if ((!m_rd_n || !m_wr_n) && !seen_strobe) begin
                chk(setup_cnt == cur_h, "R9", "cs lead cycles", 16'(setup_cnt), 16'(cur_h));
                seen_strobe = 1;
            end
            if (!m_wr_n) begin
                low_cnt++;
                wr_dat  = m_dout;
                last_dc = m_dc;
            end
            if (!m_rd_n) begin
                low_cnt++;
                last_dc = m_dc;
                if (!rd_drv && rd_idx < 2) begin
                    din16  = rd_vals[rd_idx];
                    din8   = rd_vals[rd_idx][7:0];
                    rd_drv = 1;
                end
            end
            if ((!prev_wr && m_wr_n) || (!prev_rd && m_rd_n)) begin
                chk(low_cnt == cur_h, "R9", "strobe low cycles", 16'(low_cnt), 16'(cur_h));
                if (beat_q.size() == 0) begin
                    chk(0, "R2", "unexpected strobe beat", 16'h0, 16'h0);
                end else begin
                    logic [17:0] e;
                    string t;
                    e = beat_q.pop_front();
                    t = beat_tag_q.pop_front();
                    chk(e[17] == !prev_rd, t, "beat direction", {15'h0, !prev_rd}, {15'h0, e[17]});
                    chk(e[16] == last_dc, t, "beat dc", {15'h0, last_dc}, {15'h0, e[16]});
                    if (!e[17]) chk(wr_dat == e[15:0], t, "write beat data", wr_dat, e[15:0]);
                end
                if (!prev_rd) begin
                    // move the bus away right after the rising strobe (R10)
                    rd_idx++;
                    rd_drv = 0;
                    din16  = 16'hDEAD;
                    din8   = 8'hA7;
                end
                low_cnt = 0;
            end
            if (m_done) begin
                chk(m_cs_n == 1'b1, "R12", "cs high at done", {15'h0, m_cs_n}, 16'h1);
                if (res_q.size() == 0) begin
                    chk(0, "R12", "unexpected done", 16'h0, 16'h0);
                end else begin
                    logic [16:0] r;
                    string t;
                    r = res_q.pop_front();
                    t = res_tag_q.pop_front();
                    if (r[16]) chk(m_rdat == r[15:0], t, "read result", m_rdat, r[15:0]);
                end
            end
            prev_wr = m_wr_n;
            prev_rd = m_rd_n;
        end
    end

    // driver: push expectations, issue request, wait for completion and gap
    task automatic run_op(input int s, input logic [2:0] o, input logic [15:0] w,
                          input logic [7:0] d, input logic [15:0] r0, input logic [15:0] r1,
                          input bit poke);
        bit narrow;
        string rtag;
        int n;
        narrow = (s == 1);
        sel    = s;
        cur_h  = ((d >> 1) == 0) ? 1 : int'(d >> 1);
        rd_vals[0] = r0;
        rd_vals[1] = r1;
        rd_idx = 0;
        rd_drv = 0;
        cur_wr = (o <= 3'd2);
        cur_dc = !((o == 3'd0) || (o == 3'd3));
        rtag   = narrow ? "R7/R10" : "R8/R10";
        case (o)
            3'd0: begin cur_tag = "R3"; beat_q.push_back({2'b00, 8'h00, w[7:0]}); beat_tag_q.push_back("R3"); end
            3'd1: begin cur_tag = "R6"; beat_q.push_back({2'b01, 8'h00, w[7:0]}); beat_tag_q.push_back("R6"); end
            3'd2: begin
                cur_tag = "R6";
                if (narrow) begin
                    beat_q.push_back({2'b01, 8'h00, w[15:8]}); beat_tag_q.push_back("R6");
                    beat_q.push_back({2'b01, 8'h00, w[7:0]});  beat_tag_q.push_back("R6");
                end else begin
                    beat_q.push_back({2'b01, w}); beat_tag_q.push_back("R6");
                end
            end
            3'd3: begin cur_tag = "R4"; beat_q.push_back({2'b10, 16'h0}); beat_tag_q.push_back("R4"); end
            default: begin
                cur_tag = "R5";
                beat_q.push_back({2'b11, 16'h0}); beat_tag_q.push_back("R5");
                beat_q.push_back({2'b11, 16'h0}); beat_tag_q.push_back("R5");
            end
        endcase
        case (o)
            3'd3: res_q.push_back({1'b1, 8'h00, narrow ? r0[7:0] : r0[15:8]});
            3'd4: res_q.push_back({1'b1, 8'h00, narrow ? r1[7:0] : r1[15:8]});
            3'd5: res_q.push_back({1'b1, narrow ? {r0[7:0], r1[7:0]} : {r1[7:0], r1[15:8]}});
            default: res_q.push_back({1'b0, 16'h0});
        endcase
        res_tag_q.push_back(rtag);
        @(negedge clk);
        op = o; wd = w; dv = d;
        if (narrow) v8 = 1'b1; else v16 = 1'b1;
        @(negedge clk);
        v8 = 1'b0; v16 = 1'b0;
        dv = 8'd40; op = 3'd2; wd = 16'hFFFF; // divider is not re-sampled (R9)
        if (poke) begin
            @(negedge clk);
            op = 3'd0; wd = 16'h0077;
            if (narrow) v8 = 1'b1; else v16 = 1'b1;
            @(negedge clk);
            v8 = 1'b0; v16 = 1'b0;
        end
        n = 0;
        while (!m_done && n < 5000) begin @(negedge clk); n++; end
        chk(n < 5000, cur_tag, "done seen", 16'(n), 16'h0);
        n = 0;
        while (m_busy && n < 5000) begin n++; @(negedge clk); end
        chk(n == cur_h, "R12", "busy cycles after release", 16'(n), 16'(cur_h));
        chk(beat_q.size() == 0, cur_tag, "all beats made", 16'(beat_q.size()), 16'h0);
        if (poke) begin
            repeat (4 * cur_h + 4) @(negedge clk);
            chk(m_cs_n && !m_busy, "R2", "request while busy dropped", {15'h0, m_busy}, 16'h0);
        end
    endtask

    task automatic try_unused(input int s, input logic [2:0] o);
        sel = s;
        @(negedge clk);
        op = o;
        if (s == 1) v8 = 1'b1; else v16 = 1'b1;
        @(negedge clk);
        v8 = 1'b0; v16 = 1'b0;
        repeat (3) begin
            chk(!m_busy && m_cs_n, "R2", "unused code ignored", {15'h0, m_busy}, 16'h0);
            @(negedge clk);
        end
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual %0d expected less", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(b16_cs_n && b16_rd_n && b16_wr_n && !b16_oe && !b16_busy && !b16_done, "R1",
            "reset state wide", {10'h0, b16_cs_n, b16_rd_n, b16_wr_n, b16_oe, b16_busy, b16_done}, 16'h38);
        chk(b8_cs_n && b8_rd_n && b8_wr_n && !b8_oe && !b8_busy && !b8_done, "R1",
            "reset state narrow", {10'h0, b8_cs_n, b8_rd_n, b8_wr_n, b8_oe, b8_busy, b8_done}, 16'h38);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // 16-bit bus
        run_op(0, 3'd0, 16'hA55A, 8'd2,  16'h0, 16'h0, 0);
        run_op(0, 3'd1, 16'h9C3E, 8'd4,  16'h0, 16'h0, 0);
        run_op(0, 3'd2, 16'h1234, 8'd6,  16'h0, 16'h0, 0);
        run_op(0, 3'd3, 16'h0,    8'd2,  16'hC3A5, 16'h0, 0);
        run_op(0, 3'd4, 16'h0,    8'd7,  16'h1111, 16'h2299, 0);
        run_op(0, 3'd5, 16'h0,    8'd0,  16'h0100, 16'hFF01, 0);
        run_op(0, 3'd5, 16'h0,    8'd10, 16'h4321, 16'h8765, 1);

        // 8-bit bus
        run_op(1, 3'd0, 16'h7E44, 8'd2,  16'h0, 16'h0, 0);
        run_op(1, 3'd1, 16'h00C8, 8'd4,  16'h0, 16'h0, 0);
        run_op(1, 3'd2, 16'hBEEF, 8'd1,  16'h0, 16'h0, 0);
        run_op(1, 3'd3, 16'h0,    8'd4,  16'h005A, 16'h0, 0);
        run_op(1, 3'd4, 16'h0,    8'd2,  16'h0001, 16'h00FF, 0);
        run_op(1, 3'd5, 16'h0,    8'd4,  16'h0001, 16'h00FF, 0);
        run_op(1, 3'd2, 16'h5AC3, 8'd6,  16'h0, 16'h0, 1);

        try_unused(0, 3'd6);
        try_unused(1, 3'd7);
        repeat (4) @(negedge clk);
        chk(res_q.size() == 0, "R12", "all results seen", 16'(res_q.size()), 16'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule